// File: doc/BRIEF.md
# Dual-Domain Reset Sequencer

This block turns one raw reset request into two reset outputs for two unrelated clock domains. One is an active-high reset for a PHY management domain. The other is an active-low reset for a protocol core domain. Both outputs go to their reset level at once, with no clock, whenever the request is high. Each output is then released by a two-flop synchronizer on its own clock.

A transceiver reconfiguration busy input holds both resets for as long as it is high. It is brought into each domain through its own synchronizer. If busy rises again after release, both resets go active again. The core reset also waits a minimum number of core clock cycles before it lets go. That count starts over on every new request and on every rise of busy.

Top module: `rstseq_top`

## Requirements
- R1: While `rst_req` is high, `mgmt_rst` is 1 and `core_rst_n` is 0.
- R2: A rising `rst_req` drives `mgmt_rst` to 1 and `core_rst_n` to 0 within 1 ns, with no clock edge needed.
- R3: `mgmt_rst` falls on the (SYNC_STAGES+1)-th rising edge of `clk_mgmt` after the later of the falls of `rst_req` and `reconfig_busy`. This is the third edge with default parameters. The hold count does not delay it.
- R4: Neither output is released while `reconfig_busy` is high, however long it stays high.
- R5: `core_rst_n` rises on the (SYNC_STAGES+1+HOLD_CYCLES)-th rising edge of `clk_core` after the later of the falls of `rst_req` and `reconfig_busy`.
- R6: A new request that arrives while the hold count is running restarts the count. So does a busy pulse during the count. After either one ends, R5's full delay applies again.
- R7: A rise of `reconfig_busy` after release re-asserts `mgmt_rst` on the third `clk_mgmt` edge and `core_rst_n` on the third `clk_core` edge. Both outputs are then released again as in R3 and R5.
- R8: Each output is released only at a rising edge of its own clock. The two releases need not occur together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_mgmt | input | 1 | PHY management clock |
| clk_core | input | 1 | Protocol core clock |
| rst_req | input | 1 | Raw reset request, active high, asynchronous |
| reconfig_busy | input | 1 | Reconfiguration logic busy, asynchronous |
| mgmt_rst | output | 1 | Management domain reset, active high |
| core_rst_n | output | 1 | Core domain reset, active low |

## Verification
The bench builds the block with HOLD_CYCLES set to 5 and SYNC_STAGES left at 2. This puts the core release on the eighth core edge, so the exact release cycle is checked in every scenario. It also lets a request or a busy pulse land part way through the hold count. The two clocks run at 10 ns and 14 ns. Their edges drift against each other, which shows that each release follows only its own clock.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

  // Width of a counter that must reach 'limit'
  function automatic int cnt_w(input int limit);
    int w;
    w = $clog2(limit + 1);
    return (w < 1) ? 1 : w;
  endfunction

  // Number of destination clock edges from the last cause falling to release
  function automatic int release_edges(input int stages, input int hold);
    return stages + 1 + hold;
  endfunction

endpackage

// File: rtl/rstseq_sync2.sv
module rstseq_sync2 #(
  parameter int STAGES  = 2,
  parameter bit SET_VAL = 1'b1
) (
  input  logic clk,
  input  logic arst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or posedge arst) begin
        if (arst) chain <= {STAGES{SET_VAL}};
        else      chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk or posedge arst) begin
        if (arst) chain <= {STAGES{SET_VAL}};
        else      chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rstseq_hold_cnt.sv
module rstseq_hold_cnt
  import rstseq_pkg::*;
#(
  parameter int HOLD_CYCLES = 16
) (
  input  logic clk,
  input  logic arst,
  input  logic clear,
  output logic done
);
  localparam int             W   = cnt_w(HOLD_CYCLES);
  localparam logic [W-1:0]   LIM = W'(HOLD_CYCLES);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or posedge arst) begin
    if (arst)            cnt <= '0;
    else if (clear)      cnt <= '0;
    else if (cnt != LIM) cnt <= cnt + 1'b1;
  end

  assign done = (cnt == LIM);
endmodule

// File: rtl/rstseq_domain.sv
module rstseq_domain #(
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_CYCLES = 0,
  parameter bit ACTIVE_HIGH = 1'b1
) (
  input  logic clk,
  input  logic arst,
  input  logic busy_i,
  output logic rst_o,
  output logic req_sync_o,
  output logic busy_sync_o,
  output logic hold_done_o
);
  logic req_s, busy_s, hold_done, release_ok, rst_act;

  // Request synchronizer: asserts at once, clears over SYNC_STAGES edges
  rstseq_sync2 #(.STAGES(SYNC_STAGES), .SET_VAL(1'b1)) u_req_sync (
    .clk (clk), .arst(arst), .d(1'b0), .q(req_s)
  );

  // Busy synchronizer: treated as busy while the request is active
  rstseq_sync2 #(.STAGES(SYNC_STAGES), .SET_VAL(1'b1)) u_busy_sync (
    .clk (clk), .arst(arst), .d(busy_i), .q(busy_s)
  );

  generate
    if (HOLD_CYCLES > 0) begin : g_hold
      rstseq_hold_cnt #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
        .clk  (clk),
        .arst (arst),
        .clear(req_s | busy_s),
        .done (hold_done)
      );
    end else begin : g_nohold
      assign hold_done = 1'b1;
    end
  endgenerate

  assign release_ok = !req_s && !busy_s && hold_done;

  always_ff @(posedge clk or posedge arst) begin
    if (arst) rst_act <= 1'b1;
    else      rst_act <= !release_ok;
  end

  assign rst_o       = ACTIVE_HIGH ? rst_act : !rst_act;
  assign req_sync_o  = req_s;
  assign busy_sync_o = busy_s;
  assign hold_done_o = hold_done;
endmodule

// File: rtl/rstseq_top.sv
module rstseq_top #(
  parameter int HOLD_CYCLES = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_mgmt,
  input  logic clk_core,
  input  logic rst_req,
  input  logic reconfig_busy,
  output logic mgmt_rst,
  output logic core_rst_n
);
  logic mgmt_req_sync, mgmt_busy_sync, mgmt_hold_done;
  logic core_req_sync, core_busy_sync, core_hold_done;

  rstseq_domain #(
    .SYNC_STAGES(SYNC_STAGES), .HOLD_CYCLES(0), .ACTIVE_HIGH(1'b1)
  ) u_mgmt (
    .clk        (clk_mgmt),
    .arst       (rst_req),
    .busy_i     (reconfig_busy),
    .rst_o      (mgmt_rst),
    .req_sync_o (mgmt_req_sync),
    .busy_sync_o(mgmt_busy_sync),
    .hold_done_o(mgmt_hold_done)
  );

  rstseq_domain #(
    .SYNC_STAGES(SYNC_STAGES), .HOLD_CYCLES(HOLD_CYCLES), .ACTIVE_HIGH(1'b0)
  ) u_core (
    .clk        (clk_core),
    .arst       (rst_req),
    .busy_i     (reconfig_busy),
    .rst_o      (core_rst_n),
    .req_sync_o (core_req_sync),
    .busy_sync_o(core_busy_sync),
    .hold_done_o(core_hold_done)
  );
endmodule

// File: rtl/rstseq_checker.sv
module rstseq_checker
  import rstseq_pkg::*;
#(
  parameter int HOLD_CYCLES = 16,
  parameter int SYNC_STAGES = 2
) (
  input logic clk_mgmt,
  input logic clk_core,
  input logic rst_req,
  input logic mgmt_rst,
  input logic core_rst_n,
  input logic mgmt_busy_sync,
  input logic core_busy_sync,
  input logic core_req_sync
);
  localparam int CORE_MIN = release_edges(SYNC_STAGES, HOLD_CYCLES) - 1;
  localparam int MGMT_MIN = SYNC_STAGES;

  int core_low_cnt;
  int mgmt_hi_cnt;

  always_ff @(posedge clk_core or posedge rst_req) begin
    if (rst_req)         core_low_cnt <= 0;
    else if (core_rst_n) core_low_cnt <= 0;
    else if (core_low_cnt < 100000) core_low_cnt <= core_low_cnt + 1;
  end

  always_ff @(posedge clk_mgmt or posedge rst_req) begin
    if (rst_req)       mgmt_hi_cnt <= 0;
    else if (!mgmt_rst) mgmt_hi_cnt <= 0;
    else if (mgmt_hi_cnt < 100000) mgmt_hi_cnt <= mgmt_hi_cnt + 1;
  end

  // R1: request active means both outputs at their reset level
  always @(posedge clk_core) begin
    if (rst_req) p_req_core_r1: assert (mgmt_rst && !core_rst_n);
  end
  always @(posedge clk_mgmt) begin
    if (rst_req) p_req_mgmt_r1: assert (mgmt_rst && !core_rst_n);
  end

  p_busy_core_r4: assert property (@(posedge clk_core) disable iff (rst_req)
    core_busy_sync |=> !core_rst_n);

  p_busy_mgmt_r4: assert property (@(posedge clk_mgmt) disable iff (rst_req)
    mgmt_busy_sync |=> mgmt_rst);

  p_core_min_hold_r5: assert property (@(posedge clk_core) disable iff (rst_req)
    $rose(core_rst_n) |-> (core_low_cnt >= CORE_MIN));

  p_mgmt_min_hold_r3: assert property (@(posedge clk_mgmt) disable iff (rst_req)
    $fell(mgmt_rst) |-> (mgmt_hi_cnt >= MGMT_MIN));

  p_req_sync_core_r6: assert property (@(posedge clk_core) disable iff (rst_req)
    core_req_sync |=> !core_rst_n);
endmodule

bind rstseq_top rstseq_checker #(
  .HOLD_CYCLES(HOLD_CYCLES), .SYNC_STAGES(SYNC_STAGES)
) u_rstseq_chk (
  .clk_mgmt      (clk_mgmt),
  .clk_core      (clk_core),
  .rst_req       (rst_req),
  .mgmt_rst      (mgmt_rst),
  .core_rst_n    (core_rst_n),
  .mgmt_busy_sync(mgmt_busy_sync),
  .core_busy_sync(core_busy_sync),
  .core_req_sync (core_req_sync)
);

// File: tb/rstseq_top_bench.sv
module rstseq_top_bench;
  localparam int MGMT_PERIOD = 10;
  localparam int CORE_PERIOD = 14;
  localparam int HOLD        = 5;
  localparam int STAGES      = 2;
  localparam int MGMT_EDGES  = STAGES + 1;
  localparam int CORE_EDGES  = STAGES + 1 + HOLD;
  localparam int NVEC        = 6;
  // columns: request length ns, busy used, extra busy time ns (all even)
  localparam int VEC [NVEC][3] = '{
    '{40, 0, 0}, '{12, 0, 0}, '{60, 1, 0},
    '{30, 1, 40}, '{20, 1, 150}, '{100, 1, 300}
  };

  logic clk_mgmt = 1'b0;
  logic clk_core = 1'b0;
  logic rst_req = 1'b0;
  logic reconfig_busy = 1'b0;
  logic mgmt_rst, core_rst_n;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(MGMT_PERIOD/2) clk_mgmt = ~clk_mgmt;
  always #(CORE_PERIOD/2) clk_core = ~clk_core;

  rstseq_top #(.HOLD_CYCLES(HOLD), .SYNC_STAGES(STAGES)) u_rstseq_top (
    .clk_mgmt     (clk_mgmt),
    .clk_core     (clk_core),
    .rst_req      (rst_req),
    .reconfig_busy(reconfig_busy),
    .mgmt_rst     (mgmt_rst),
    .core_rst_n   (core_rst_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Count clk_mgmt edges until mgmt_rst reaches 'lvl'
  task automatic edges_mgmt(input logic lvl, output int n);
    n = 0;
    while (n < 200) begin
      @(posedge clk_mgmt); n++; #1;
      if (mgmt_rst == lvl) break;
    end
  endtask

  task automatic edges_core(input logic lvl, output int n);
    n = 0;
    while (n < 200) begin
      @(posedge clk_core); n++; #1;
      if (core_rst_n == lvl) break;
    end
  endtask

  task automatic both_release(input string tag);
    int nm, nc;
    fork
      edges_mgmt(1'b0, nm);
      edges_core(1'b1, nc);
    join
    chk(nm == MGMT_EDGES, {tag, " R3 mgmt release edge"}, nm, MGMT_EDGES);
    chk(nc == CORE_EDGES, {tag, " R5 core release edge"}, nc, CORE_EDGES);
  endtask

  initial begin
    #(MGMT_PERIOD * 150000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #2 rst_req = 1'b1;
    #2;
    // R1: reset state
    chk(mgmt_rst == 1'b1, "R1 mgmt_rst at reset", mgmt_rst, 1);
    chk(core_rst_n == 1'b0, "R1 core_rst_n at reset", core_rst_n, 0);
    #40 rst_req = 1'b0;
    both_release("init");

    // Table of scenarios
    for (int i = 0; i < NVEC; i++) begin
      #20;
      rst_req = 1'b1;
      reconfig_busy = VEC[i][1][0];
      #1;
      chk(mgmt_rst == 1'b1, "R2 mgmt asserts at once", mgmt_rst, 1);
      chk(core_rst_n == 1'b0, "R2 core asserts at once", core_rst_n, 0);
      #(VEC[i][0] - 1);
      rst_req = 1'b0;
      if (VEC[i][1] != 0) begin
        if (VEC[i][2] > 0) begin
          #(VEC[i][2]);
          chk(mgmt_rst == 1'b1, "R4 mgmt held by busy", mgmt_rst, 1);
          chk(core_rst_n == 1'b0, "R4 core held by busy", core_rst_n, 0);
        end
        reconfig_busy = 1'b0;
      end
      both_release($sformatf("vec%0d", i));
    end

    // R6: new request in the middle of the hold count
    #20 rst_req = 1'b1;
    #30 rst_req = 1'b0;
    repeat (STAGES + 3) @(posedge clk_core);
    #1;
    chk(core_rst_n == 1'b0, "R6 core still held mid count", core_rst_n, 0);
    rst_req = 1'b1;
    #1;
    chk(mgmt_rst == 1'b1, "R2 mgmt reasserts on new request", mgmt_rst, 1);
    #19 rst_req = 1'b0;
    both_release("R6 request restart");

    // R6: busy pulse during the hold count
    #20 rst_req = 1'b1;
    #30 rst_req = 1'b0;
    repeat (STAGES + 3) @(posedge clk_core);
    #1 reconfig_busy = 1'b1;
    #40 reconfig_busy = 1'b0;
    begin
      int nc;
      edges_core(1'b1, nc);
      chk(nc == CORE_EDGES, "R6 busy pulse restarts hold", nc, CORE_EDGES);
    end

    // R7: busy rises after release
    #40;
    chk(mgmt_rst == 1'b0 && core_rst_n == 1'b1, "R7 both released before busy",
        {mgmt_rst, core_rst_n}, 1);
    reconfig_busy = 1'b1;
    begin
      int nm, nc;
      fork
        edges_mgmt(1'b1, nm);
        edges_core(1'b0, nc);
      join
      chk(nm == STAGES + 1, "R7 mgmt reassert edge", nm, STAGES + 1);
      chk(nc == STAGES + 1, "R7 core reassert edge", nc, STAGES + 1);
    end
    #60;
    reconfig_busy = 1'b0;
    both_release("R7 after busy");

    // R8: release lines up with own clock edge, checked just before and after
    #20 rst_req = 1'b1;
    #20 rst_req = 1'b0;
    repeat (CORE_EDGES) @(posedge clk_core);
    #0;
    chk(core_rst_n == 1'b0, "R8 core low just at its edge before update", core_rst_n, 0);
    #1;
    chk(core_rst_n == 1'b1, "R8 core high right after its edge", core_rst_n, 1);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule